// File: doc/BRIEF.md
# Dual-Domain Reset Release Controller

This block turns one chip reset into two local resets. The chip reset is synchronous to a primary clock that always runs. The block drives one reset output for the primary clock domain and one for a secondary clock domain. The secondary clock may start long after the chip reset has gone away. The secondary domain must still see a full assertion of its reset followed by a clean release.

The primary side does not release on its own. It raises a request, and the request crosses into the secondary domain through a two-flop synchronizer. The synchronized request comes back through two primary-clock flops. The primary side keeps its reset until that echo has been seen high and then low again. Each domain then waits out its own programmable number of local cycles before its registered reset output falls. The falling edge therefore lands on a local clock edge, and downstream logic may use the output as either a synchronous or an asynchronous reset.

A status flag in the primary domain reports when both domains have come out of reset.

Top module: `dual_rst_release`

## Requirements
- R1: At power-up, before any clock edge, `rst_pri_o` and `rst_sec_o` are 1 and `both_rel_o` is 0.
- R2: On every `clk_pri` edge that samples `rst_in` high, `rst_pri_o` is 1 and `both_rel_o` is 0 after that edge.
- R3: `rst_pri_o` stays 1 until the returned request has been seen high with `rst_in` low and then seen low. The request reaches the secondary domain through two `clk_sec` flops and returns through two `clk_pri` flops. While `clk_sec` has never toggled, `rst_pri_o` therefore stays 1 even after `rst_in` falls.
- R4: `rst_pri_o` falls on the PRI_REL_CYCLES-th consecutive `clk_pri` edge at which the controller is in its run state and `rst_in` is low. The run state is entered on the edge that samples the returned request low.
- R5: `rst_sec_o` is 1 after every `clk_sec` edge that samples the synchronized request high. It falls on the SEC_REL_CYCLES-th consecutive `clk_sec` edge at which the synchronized request is low.
- R6: `rst_sec_o` cannot fall before the secondary domain has captured at least one request.
- R7: On each `clk_pri` edge, `both_rel_o` becomes 1 only when all of these hold before that edge: `rst_in` is low, the controller is in its run state, `rst_pri_o` is low, and `rst_sec_o` is low as seen through two `clk_pri` flops. Otherwise it becomes 0.
- R8: When reset reasserts in a domain during its countdown, that domain's count starts again from zero, so the full delay applies again.
- R9: If `rst_in` is reasserted while `clk_sec` is stopped, `rst_pri_o` stays 1 until `clk_sec` resumes and a new handshake completes.
- R10: If `rst_in` goes high while the controller is waiting for the returned request to fall, the controller does not enter its run state. After the request falls, it starts a fresh handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pri | input | 1 | Primary clock, always running |
| clk_sec | input | 1 | Secondary clock, may start late or stop |
| rst_in | input | 1 | Chip reset, active high, synchronous to clk_pri |
| rst_pri_o | output | 1 | Registered reset for the primary domain, active high |
| rst_sec_o | output | 1 | Registered reset for the secondary domain, active high |
| both_rel_o | output | 1 | High when both domains are out of reset, synchronous to clk_pri |

## Verification
Properties are evaluated on every cycle. They cover these rules:
- A held or reset-sampled domain always drives its reset high.
- The secondary reset cannot fall before the domain has captured a request.
- The controller never leaves the hold or drop wait until the returned request changes.
- The status flag never coexists with an asserted primary reset.

Only the scenarios can show the exact release cycles after the two-clock round trip. The same holds for these cases:
- A late-starting secondary clock.
- A clock stop followed by a new chip reset.
- A reset pulse landing mid-countdown.
- A reset pulse landing while the controller waits for the echo to fall.

// File: rtl/drr_pkg.sv
package drr_pkg;

    // Primary-side handshake phases
    typedef enum logic [1:0] {
        HS_HOLD = 2'd0,   // request raised, waiting for echo high
        HS_DROP = 2'd1,   // request lowered, waiting for echo low
        HS_RUN  = 2'd2    // handshake done, primary countdown may proceed
    } hs_state_e;

    // Controls from the primary handshake to the rest of the block
    typedef struct packed {
        logic req;    // request forwarded to the secondary domain
        logic hold;   // keep the primary countdown cleared
        logic run;    // handshake complete
    } hs_ctl_t;

    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/drr_sync2.sv
module drr_sync2 #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q = {STAGES{INIT}};

    always_ff @(posedge clk) begin
        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/drr_release_delay.sv
module drr_release_delay
    import drr_pkg::*;
#(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic hold_i,
    output logic rst_o
);
    localparam int         W     = cnt_bits(CYCLES);
    localparam logic [W-1:0] LIMIT = W'(CYCLES);

    logic [W-1:0] cnt_q = '0;
    logic         rst_q = 1'b1;
    logic [W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + 1'b1;

    // Count clean cycles; any held cycle restarts from zero
    always_ff @(posedge clk) begin
        if (hold_i) begin
            cnt_q <= '0;
            rst_q <= 1'b1;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_inc;
            rst_q <= (cnt_inc != LIMIT);
        end
    end

    assign rst_o = rst_q;
endmodule

// File: rtl/drr_handshake_a.sv
module drr_handshake_a
    import drr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_in_i,
    input  logic    echo_i,
    output hs_ctl_t ctl_o
);
    hs_state_e state_q = HS_HOLD;
    logic      pend_q  = 1'b0;

    always_ff @(posedge clk) begin
        case (state_q)
            HS_HOLD: begin
                pend_q <= 1'b0;
                if (!rst_in_i && echo_i) state_q <= HS_DROP;
            end
            HS_DROP: begin
                if (!echo_i) begin
                    pend_q  <= 1'b0;
                    state_q <= (rst_in_i || pend_q) ? HS_HOLD : HS_RUN;
                end else if (rst_in_i) begin
                    pend_q <= 1'b1;
                end
            end
            HS_RUN: begin
                if (rst_in_i) state_q <= HS_HOLD;
            end
            default: begin
                state_q <= HS_HOLD;
                pend_q  <= 1'b0;
            end
        endcase
    end

    assign ctl_o.req  = (state_q == HS_HOLD);
    assign ctl_o.run  = (state_q == HS_RUN);
    assign ctl_o.hold = rst_in_i || (state_q != HS_RUN);

    AST_HOLD_WAITS_ECHO: assert property (@(posedge clk) disable iff (rst_in_i)
        (state_q == HS_HOLD && !echo_i) |=> (state_q == HS_HOLD)); // R3
    AST_DROP_WAITS_FALL: assert property (@(posedge clk) disable iff (rst_in_i)
        (state_q == HS_DROP && echo_i) |=> (state_q == HS_DROP)); // R3
    AST_PENDING_REHOLD: assert property (@(posedge clk) disable iff (rst_in_i)
        (state_q == HS_DROP && pend_q && !echo_i) |=> (state_q == HS_HOLD)); // R10
endmodule

// File: rtl/dual_rst_release.sv
module dual_rst_release
    import drr_pkg::*;
#(
    parameter int PRI_REL_CYCLES = 4,
    parameter int SEC_REL_CYCLES = 3,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk_pri,
    input  logic clk_sec,
    input  logic rst_in,
    output logic rst_pri_o,
    output logic rst_sec_o,
    output logic both_rel_o
);
    hs_ctl_t ctl;
    logic    echo_pri;
    logic    sec_rst_seen;
    logic    fwd_sec;
    logic    sec_hold;
    logic    armed_q = 1'b0;
    logic    ready_q = 1'b0;

    // ---------------- primary domain ----------------
    drr_handshake_a u_hs (
        .clk      (clk_pri),
        .rst_in_i (rst_in),
        .echo_i   (echo_pri),
        .ctl_o    (ctl)
    );

    drr_release_delay #(.CYCLES(PRI_REL_CYCLES)) u_pri_delay (
        .clk    (clk_pri),
        .hold_i (ctl.hold),
        .rst_o  (rst_pri_o)
    );

    drr_sync2 #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_echo_sync (
        .clk (clk_pri),
        .d_i (fwd_sec),
        .q_o (echo_pri)
    );

    drr_sync2 #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_back_sync (
        .clk (clk_pri),
        .d_i (rst_sec_o),
        .q_o (sec_rst_seen)
    );

    always_ff @(posedge clk_pri) begin
        ready_q <= !rst_in && ctl.run && !rst_pri_o && !sec_rst_seen;
    end

    assign both_rel_o = ready_q;

    // ---------------- secondary domain ----------------
    drr_sync2 #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_fwd_sync (
        .clk (clk_sec),
        .d_i (ctl.req),
        .q_o (fwd_sec)
    );

    // Not armed until a request has been captured at least once
    always_ff @(posedge clk_sec) begin
        armed_q <= armed_q | fwd_sec;
    end

    assign sec_hold = !armed_q || fwd_sec;

    drr_release_delay #(.CYCLES(SEC_REL_CYCLES)) u_sec_delay (
        .clk    (clk_sec),
        .hold_i (sec_hold),
        .rst_o  (rst_sec_o)
    );

    // ---------------- checks ----------------
    AST_RSTIN_FORCES_PRI: assert property (@(posedge clk_pri)
        $past(rst_in) |-> (rst_pri_o && !both_rel_o)); // R2
    AST_PRI_FALL_UNHELD: assert property (@(posedge clk_pri) disable iff (rst_in)
        $fell(rst_pri_o) |-> !$past(ctl.hold)); // R4
    AST_PRI_HOLD_RESTART: assert property (@(posedge clk_pri) disable iff (rst_in)
        ctl.hold |=> rst_pri_o); // R8
    AST_READY_MEANS_FREE: assert property (@(posedge clk_pri) disable iff (rst_in)
        both_rel_o |-> !rst_pri_o); // R7
    AST_SEC_FOLLOWS_REQ: assert property (@(posedge clk_sec) disable iff (rst_in)
        fwd_sec |=> rst_sec_o); // R5
    AST_SEC_UNARMED_HELD: assert property (@(posedge clk_sec) disable iff (rst_in)
        !armed_q |-> rst_sec_o); // R6
endmodule

// File: tb/dual_rst_release_tb_top.sv
module dual_rst_release_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SEC_HALF   = 7;
    localparam int PRI_N      = 4;
    localparam int SEC_M      = 3;

    logic clk_pri = 1'b0;
    logic clk_sec = 1'b0;
    logic rst_in  = 1'b1;
    logic sec_run = 1'b0;
    logic rst_pri_o, rst_sec_o, both_rel_o;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string cur_tag = "R1";

    // Reference model state
    int m_state = 0;            // 0 hold, 1 drop, 2 run
    bit m_pend  = 1'b0;
    int m_acnt  = 0;
    bit m_arst  = 1'b1;
    bit m_ready = 1'b0;
    bit echo_q[$] = '{1'b0, 1'b0};
    bit back_q[$] = '{1'b1, 1'b1};
    bit fwd_q[$]  = '{1'b0, 1'b0};
    bit m_armed = 1'b0;
    int m_bcnt  = 0;
    bit m_brst  = 1'b1;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    dual_rst_release #(.PRI_REL_CYCLES(PRI_N), .SEC_REL_CYCLES(SEC_M)) dut_i (
        .clk_pri    (clk_pri),
        .clk_sec    (clk_sec),
        .rst_in     (rst_in),
        .rst_pri_o  (rst_pri_o),
        .rst_sec_o  (rst_sec_o),
        .both_rel_o (both_rel_o)
    );

    initial forever #(CLK_PERIOD / 2) clk_pri = ~clk_pri;

    // Secondary rises only on even times; primary rises on odd times
    initial begin
        #1;
        forever begin
            #SEC_HALF;
            if (sec_run) clk_sec = 1'b1;
            #SEC_HALF;
            clk_sec = 1'b0;
        end
    end

    // Primary-side model
    always @(posedge clk_pri) begin
        bit echo_now, back_now, hold_now;
        echo_now = echo_q[1];
        back_now = back_q[1];
        m_ready  = !rst_in && (m_state == 2) && !m_arst && !back_now;
        hold_now = rst_in || (m_state != 2);
        if (hold_now) begin
            m_acnt = 0;
            m_arst = 1'b1;
        end else if (m_acnt < PRI_N) begin
            m_acnt++;
            m_arst = (m_acnt < PRI_N);
        end
        if (m_state == 0) begin
            m_pend = 1'b0;
            if (!rst_in && echo_now) m_state = 1;
        end else if (m_state == 1) begin
            if (!echo_now) begin
                m_state = (rst_in || m_pend) ? 0 : 2;
                m_pend  = 1'b0;
            end else if (rst_in) begin
                m_pend = 1'b1;
            end
        end else if (rst_in) begin
            m_state = 0;
        end
        echo_q.push_front(fwd_q[1]);
        void'(echo_q.pop_back());
        back_q.push_front(m_brst);
        void'(back_q.pop_back());
    end

    // Secondary-side model
    always @(posedge clk_sec) begin
        bit f_now, hold_b;
        f_now  = fwd_q[1];
        hold_b = !m_armed || f_now;
        if (hold_b) begin
            m_bcnt = 0;
            m_brst = 1'b1;
        end else if (m_bcnt < SEC_M) begin
            m_bcnt++;
            m_brst = (m_bcnt < SEC_M);
        end
        m_armed = m_armed | f_now;
        fwd_q.push_front(m_state == 0);
        void'(fwd_q.pop_back());
    end

    // Per-cycle comparison, away from the edges
    always @(posedge clk_pri) begin
        #2;
        if (!done) begin
            chk({cur_tag, "/R4"}, "rst_pri_o", rst_pri_o, m_arst);
            chk({cur_tag, "/R7"}, "both_rel_o", both_rel_o, m_ready);
        end
    end

    always @(posedge clk_sec) begin
        #2;
        if (!done) chk({cur_tag, "/R5"}, "rst_sec_o", rst_sec_o, m_brst);
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: power-up values before any edge
        #3;
        chk("R1", "rst_pri_o", rst_pri_o, 1'b1);
        chk("R1", "rst_sec_o", rst_sec_o, 1'b1);
        chk("R1", "both_rel_o", both_rel_o, 1'b0);

        // R3 / R6: chip reset removed while the secondary clock is absent
        repeat (3) @(negedge clk_pri);
        rst_in  = 1'b0;
        cur_tag = "R3";
        repeat (30) @(negedge clk_pri);
        chk("R3", "rst_pri_o held, no clk_sec", rst_pri_o, 1'b1);
        chk("R6", "rst_sec_o held, no capture", rst_sec_o, 1'b1);

        // Late clock start: full handshake and release
        sec_run = 1'b1;
        cur_tag = "R5";
        repeat (80) @(negedge clk_pri);
        chk("R4", "rst_pri_o released", rst_pri_o, 1'b0);
        chk("R5", "rst_sec_o released", rst_sec_o, 1'b0);
        chk("R7", "both_rel_o", both_rel_o, 1'b1);

        // R2: chip reset seen on the next edge
        cur_tag = "R2";
        rst_in = 1'b1;
        @(posedge clk_pri);
        #2;
        chk("R2", "rst_pri_o", rst_pri_o, 1'b1);
        chk("R2", "both_rel_o", both_rel_o, 1'b0);
        repeat (3) @(negedge clk_pri);
        rst_in = 1'b0;

        // R8: pulse during the primary countdown restarts it
        cur_tag = "R8";
        for (int i = 0; i < 300 && !(m_state == 2 && m_arst); i++) @(negedge clk_pri);
        chk("R8", "countdown reached", rst_pri_o, 1'b1);
        rst_in = 1'b1;
        @(negedge clk_pri);
        rst_in = 1'b0;
        repeat (80) @(negedge clk_pri);
        chk("R8", "rst_pri_o released after restart", rst_pri_o, 1'b0);

        // R10: pulse while waiting for the echo to fall
        cur_tag = "R10";
        rst_in = 1'b1;
        @(negedge clk_pri);
        rst_in = 1'b0;
        for (int i = 0; i < 300 && m_state != 1; i++) @(negedge clk_pri);
        rst_in = 1'b1;
        @(negedge clk_pri);
        rst_in = 1'b0;
        @(negedge clk_pri);
        chk("R10", "rst_pri_o during drop wait", rst_pri_o, 1'b1);
        repeat (100) @(negedge clk_pri);
        chk("R10", "rst_pri_o after fresh handshake", rst_pri_o, 1'b0);
        chk("R10", "both_rel_o", both_rel_o, 1'b1);

        // R9: chip reset while the secondary clock is stopped
        cur_tag = "R9";
        sec_run = 1'b0;
        repeat (4) @(negedge clk_pri);
        rst_in = 1'b1;
        repeat (2) @(negedge clk_pri);
        rst_in = 1'b0;
        repeat (40) @(negedge clk_pri);
        chk("R9", "rst_pri_o held while clk_sec stopped", rst_pri_o, 1'b1);
        chk("R9", "both_rel_o", both_rel_o, 1'b0);
        sec_run = 1'b1;
        repeat (100) @(negedge clk_pri);
        chk("R9", "rst_pri_o after resume", rst_pri_o, 1'b0);
        chk("R9", "rst_sec_o after resume", rst_sec_o, 1'b0);

        repeat (5) @(negedge clk_pri);
        finish_run();
    end
endmodule